// File: doc/BRIEF.md
# USB Host Command Register Controller

This block holds the command register of a host-side USB controller and runs the handshakes between that register and the schedule engine. Software reaches it through a small word-wide register bus with one write strobe and a combinational read port. It keeps the two schedule enables and the frame list size code. It also keeps two bits that hardware clears on its own. The first is a doorbell that software rings to ask for an async-advance interrupt. The second is a controller reset that runs for a fixed number of cycles.

The schedule engine pulses `evictDone` once it has dropped all cached asynchronous schedule state. That pulse latches the async-advance status flag, and the doorbell clears one cycle later. If the interrupt is enabled, the interrupt line rises at the next `thresholdTick` strobe. It stays high until software clears the status flag. The block also masks the running frame index to form the current frame list index, whose width follows the selected list size.

Register map: address 0 is the command word, with bit 0 for reset, bit 1 for the async enable, bit 2 for the periodic enable, bits 5:3 for the list size code and bit 6 for the doorbell. Address 1 is the status word: bit 0 is the async-advance flag, cleared by writing 1 to it. Address 2 is the interrupt enable, bit 0. Address 3 reads as 0.

Top module: `usbh_cmd_ctrl`

## Requirements
- R1: After the reset input is released, the command word, the status word, the interrupt enable, `asyncAdvIrq` and `ctrlResetBusy` all read 0.
- R2: Command bit 1 and command bit 2 store the async and periodic schedule enables. `asyncSchedOn` and `periodicSchedOn` follow the stored bit only while `hostMode` is 1, and are 0 otherwise.
- R3: Command bits 5:3 (the size code) take a written value only while `progListCap` is 1. While it is 0, a write leaves the stored code unchanged.
- R4: Size code c selects 1024 >> c list entries. `listIndex` equals `frameIndex[(10-c)+2:3]`, and every `listIndex` bit above that range is 0.
- R5: In host mode, writing 1 to command bit 6 sets the doorbell. It reads back on bit 6 and on `doorbellPending`. Writing 0 to bit 6 does not clear a pending doorbell.
- R6: An `evictDone` pulse while the doorbell is set sets status bit 0 at that clock edge, and the doorbell clears at the following edge. An `evictDone` pulse while the doorbell is clear has no effect.
- R7: With status bit 0 set and the interrupt enable at 1, `asyncAdvIrq` rises at the edge after the first `thresholdTick`, not before it. It stays high until a write of 1 to status bit 0, and falls at the edge after that write.
- R8: With the interrupt enable at 0, `thresholdTick` never raises `asyncAdvIrq`.
- R9: While `hostMode` is 0, a doorbell write is ignored: `doorbellPending` and command bit 6 stay 0.
- R10: Writing 1 to command bit 0 holds `ctrlResetBusy` and command bit 0 at 1 for exactly RESET_CYCLES cycles (default 16). Command writes made during that time are ignored, and a write of 0 does not shorten it.
- R11: A controller reset clears the enables, the size code, the doorbell, the status flag and `asyncAdvIrq`, and keeps the interrupt enable. The other fields carried in the write that starts the reset are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| hostMode | input | 1 | 1 = host mode, 0 = device mode |
| progListCap | input | 1 | Capability flag that unlocks the size code |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr` (combinational) |
| evictDone | input | 1 | Schedule engine: cached async state evicted |
| thresholdTick | input | 1 | Interrupt threshold strobe |
| frameIndex | input | 14 | Running frame index |
| asyncSchedOn | output | 1 | Process the asynchronous schedule |
| periodicSchedOn | output | 1 | Process the periodic schedule |
| doorbellPending | output | 1 | Async-advance doorbell is armed |
| ctrlResetBusy | output | 1 | Controller reset sequence is in progress |
| asyncAdvIrq | output | 1 | Async-advance interrupt |
| listIndex | output | 10 | Current frame list index |

## Verification
The assertions assume that `evictDone` and `thresholdTick` are single-cycle strobes. They also assume that `progListCap` changes only while no write is in flight, so the size code is stable in every cycle where the flag is 0 and no reset runs. The bench drives every input on the falling clock edge. It pulses each strobe for exactly one rising edge, and it changes the mode and capability inputs only between register writes, so each assumed condition holds for the whole run.

// File: rtl/usbh_cmd_pkg.sv
package usbh_cmd_pkg;

  // register word addresses
  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_STS  = 2'd1;
  localparam logic [1:0] ADDR_IEN  = 2'd2;

  // command word bit positions
  localparam int BIT_RST    = 0;
  localparam int BIT_ASYNC  = 1;
  localparam int BIT_PERIOD = 2;
  localparam int BIT_SIZE_LO = 3;
  localparam int BIT_SIZE_HI = 5;
  localparam int BIT_DBELL  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic clrFields;   // reset sequence running: force fields to initial values
    logic blockCmd;    // command writes are not accepted this cycle
    logic setStatus;   // latch async-advance status
    logic clrDoorbell; // hardware clears the doorbell
  } ctlStrobes_t;

endpackage

// File: rtl/usbh_cmd_ctl.sv
module usbh_cmd_ctl
  import usbh_cmd_pkg::*;
#(
  parameter int RESET_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWr,
  input  logic        wrResetBit,
  input  logic        evictDone,
  input  logic        thresholdTick,
  input  logic        doorbellQ,
  input  logic        statusQ,
  input  logic        intEnQ,
  output ctlStrobes_t strobes,
  output logic        busy,
  output logic        irq
);

  localparam int CNT_W = $clog2(RESET_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES - 1);

  logic [CNT_W-1:0] rstCnt;
  logic             startRst;
  logic             evictAck;
  logic             setSts;

  assign startRst = cmdWr && wrResetBit && !busy;

  // reset sequence counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      rstCnt <= '0;
    end else if (startRst) begin
      busy   <= 1'b1;
      rstCnt <= CNT_LOAD;
    end else if (busy) begin
      if (rstCnt == '0) busy <= 1'b0;
      else              rstCnt <= rstCnt - 1'b1;
    end
  end

  // doorbell handshake: status first, doorbell released one edge later
  assign setSts = evictDone && doorbellQ && !busy && !evictAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     evictAck <= 1'b0;
    else if (busy) evictAck <= 1'b0;
    else           evictAck <= setSts;
  end

  // interrupt raised on a threshold strobe, held until status clears
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         irq <= 1'b0;
    else if (busy || !statusQ)         irq <= 1'b0;
    else if (thresholdTick && intEnQ)  irq <= 1'b1;
  end

  always_comb begin
    strobes.clrFields   = busy;
    strobes.blockCmd    = busy || startRst;
    strobes.setStatus   = setSts;
    strobes.clrDoorbell = evictAck;
  end

  // R10: an active reset sequence is not cut short by anything
  a_r10_reset_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && rstCnt != '0) |=> busy);

  // R7: the interrupt only rises on a threshold with status and enable set
  a_r7_irq_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(thresholdTick) && $past(statusQ) && $past(intEnQ)));

  // R7: status clearing drops the interrupt on the next edge
  a_r7_irq_drops: assert property (@(posedge clk) disable iff (!rstN)
    (!statusQ && !busy) |=> !irq);

endmodule

// File: rtl/usbh_cmd_dp.sv
module usbh_cmd_dp
  import usbh_cmd_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int FRAME_IDX_W  = 14,
  parameter int LIST_LOG_MAX = 10
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostMode,
  input  logic                    progListCap,
  input  logic                    regWrEn,
  input  logic [1:0]              regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  input  logic [FRAME_IDX_W-1:0]  frameIndex,
  input  ctlStrobes_t             strobes,
  input  logic                    busy,
  output logic [DATA_W-1:0]       regRdData,
  output logic                    doorbellQ,
  output logic                    statusQ,
  output logic                    intEnQ,
  output logic                    asyncSchedOn,
  output logic                    periodicSchedOn,
  output logic [LIST_LOG_MAX-1:0] listIndex
);

  localparam int SIZE_W = BIT_SIZE_HI - BIT_SIZE_LO + 1;
  localparam int IDX_LO = 3;

  logic              asyncEnQ;
  logic              periodicEnQ;
  logic [SIZE_W-1:0] sizeCodeQ;
  logic              cmdWrOk;
  logic              stsWr;
  logic              ienWr;
  logic              unusedBits;

  assign cmdWrOk = regWrEn && (regAddr == ADDR_CMD) && !strobes.blockCmd;
  assign stsWr   = regWrEn && (regAddr == ADDR_STS);
  assign ienWr   = regWrEn && (regAddr == ADDR_IEN);

  assign unusedBits = ^{regWrData[DATA_W-1:BIT_DBELL+1],
                        frameIndex[FRAME_IDX_W-1:LIST_LOG_MAX+IDX_LO],
                        frameIndex[IDX_LO-1:0]};

  // schedule enables
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      asyncEnQ    <= 1'b0;
      periodicEnQ <= 1'b0;
    end else if (strobes.clrFields) begin
      asyncEnQ    <= 1'b0;
      periodicEnQ <= 1'b0;
    end else if (cmdWrOk) begin
      asyncEnQ    <= regWrData[BIT_ASYNC];
      periodicEnQ <= regWrData[BIT_PERIOD];
    end
  end

  // frame list size code, writable only with the capability flag
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         sizeCodeQ <= '0;
    else if (strobes.clrFields)        sizeCodeQ <= '0;
    else if (cmdWrOk && progListCap)   sizeCodeQ <= regWrData[BIT_SIZE_HI:BIT_SIZE_LO];
  end

  // doorbell: set by software in host mode, cleared by hardware only
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                            doorbellQ <= 1'b0;
    else if (strobes.clrFields || strobes.clrDoorbell)    doorbellQ <= 1'b0;
    else if (cmdWrOk && hostMode && regWrData[BIT_DBELL]) doorbellQ <= 1'b1;
  end

  // async-advance status, write 1 to clear, set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          statusQ <= 1'b0;
    else if (strobes.clrFields)         statusQ <= 1'b0;
    else if (strobes.setStatus)         statusQ <= 1'b1;
    else if (stsWr && regWrData[0])     statusQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      intEnQ <= 1'b0;
    else if (ienWr) intEnQ <= regWrData[0];
  end

  assign asyncSchedOn    = asyncEnQ && hostMode;
  assign periodicSchedOn = periodicEnQ && hostMode;

  // list index: bit b comes from frameIndex[b+3] while b < LIST_LOG_MAX - code
  for (genvar b = 0; b < LIST_LOG_MAX; b++) begin : g_idx
    localparam int unsigned SPAN = LIST_LOG_MAX - b;
    assign listIndex[b] = frameIndex[b+IDX_LO] && (32'(sizeCodeQ) < SPAN);
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CMD: begin
        regRdData[BIT_RST]                 = busy;
        regRdData[BIT_ASYNC]               = asyncEnQ;
        regRdData[BIT_PERIOD]              = periodicEnQ;
        regRdData[BIT_SIZE_HI:BIT_SIZE_LO] = sizeCodeQ;
        regRdData[BIT_DBELL]               = doorbellQ;
      end
      ADDR_STS: regRdData[0] = statusQ;
      ADDR_IEN: regRdData[0] = intEnQ;
      default:  regRdData = '0;
    endcase
  end

  // R11: a running reset leaves every command field at its initial value
  a_r11_fields_cleared: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (!asyncEnQ && !periodicEnQ && sizeCodeQ == '0 && !doorbellQ && !statusQ));

  // R3: without the capability flag the size code does not move
  a_r3_size_locked: assert property (@(posedge clk) disable iff (!rstN)
    (!progListCap && !busy) |=> $stable(sizeCodeQ));

  // R6: the doorbell is released only after status was set, or by reset
  a_r6_doorbell_after_status: assert property (@(posedge clk) disable iff (!rstN)
    $fell(doorbellQ) |-> ($past(statusQ) || $past(busy)));

  // R9: in device mode the doorbell cannot become armed
  a_r9_device_no_doorbell: assert property (@(posedge clk) disable iff (!rstN)
    (!hostMode && !doorbellQ) |=> !doorbellQ);

  // R4: list index never has bits outside the selected range
  a_r4_index_range: assert property (@(posedge clk) disable iff (!rstN)
    (listIndex >> (LIST_LOG_MAX - int'(sizeCodeQ))) == '0);

endmodule

// File: rtl/usbh_cmd_ctrl.sv
module usbh_cmd_ctrl
  import usbh_cmd_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int FRAME_IDX_W  = 14,
  parameter int LIST_LOG_MAX = 10,
  parameter int RESET_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    hostMode,
  input  logic                    progListCap,
  input  logic                    regWrEn,
  input  logic [1:0]              regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  output logic [DATA_W-1:0]       regRdData,
  input  logic                    evictDone,
  input  logic                    thresholdTick,
  input  logic [FRAME_IDX_W-1:0]  frameIndex,
  output logic                    asyncSchedOn,
  output logic                    periodicSchedOn,
  output logic                    doorbellPending,
  output logic                    ctrlResetBusy,
  output logic                    asyncAdvIrq,
  output logic [LIST_LOG_MAX-1:0] listIndex
);

  ctlStrobes_t strobes;
  logic        doorbellQ;
  logic        statusQ;
  logic        intEnQ;
  logic        busy;
  logic        cmdWr;

  assign cmdWr = regWrEn && (regAddr == ADDR_CMD);

  usbh_cmd_ctl #(
    .RESET_CYCLES(RESET_CYCLES)
  ) i_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdWr        (cmdWr),
    .wrResetBit   (regWrData[BIT_RST]),
    .evictDone    (evictDone),
    .thresholdTick(thresholdTick),
    .doorbellQ    (doorbellQ),
    .statusQ      (statusQ),
    .intEnQ       (intEnQ),
    .strobes      (strobes),
    .busy         (busy),
    .irq          (asyncAdvIrq)
  );

  usbh_cmd_dp #(
    .DATA_W      (DATA_W),
    .FRAME_IDX_W (FRAME_IDX_W),
    .LIST_LOG_MAX(LIST_LOG_MAX)
  ) i_dp (
    .clk            (clk),
    .rstN           (rstN),
    .hostMode       (hostMode),
    .progListCap    (progListCap),
    .regWrEn        (regWrEn),
    .regAddr        (regAddr),
    .regWrData      (regWrData),
    .frameIndex     (frameIndex),
    .strobes        (strobes),
    .busy           (busy),
    .regRdData      (regRdData),
    .doorbellQ      (doorbellQ),
    .statusQ        (statusQ),
    .intEnQ         (intEnQ),
    .asyncSchedOn   (asyncSchedOn),
    .periodicSchedOn(periodicSchedOn),
    .listIndex      (listIndex)
  );

  assign doorbellPending = doorbellQ;
  assign ctrlResetBusy   = busy;

endmodule

// File: tb/test_usbh_cmd_ctrl.sv
`timescale 1ns/1ps
module test_usbh_cmd_ctrl;

  localparam int RST_LEN = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostMode = 1'b1;
  logic        progListCap = 1'b1;
  logic        regWrEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        evictDone = 1'b0;
  logic        thresholdTick = 1'b0;
  logic [13:0] frameIndex = '0;
  logic        asyncSchedOn, periodicSchedOn, doorbellPending;
  logic        ctrlResetBusy, asyncAdvIrq;
  logic [9:0]  listIndex;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  usbh_cmd_ctrl #(.RESET_CYCLES(RST_LEN)) i_usbh_cmd_ctrl (
    .clk(clk), .rstN(rstN), .hostMode(hostMode), .progListCap(progListCap),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .evictDone(evictDone), .thresholdTick(thresholdTick),
    .frameIndex(frameIndex), .asyncSchedOn(asyncSchedOn),
    .periodicSchedOn(periodicSchedOn), .doorbellPending(doorbellPending),
    .ctrlResetBusy(ctrlResetBusy), .asyncAdvIrq(asyncAdvIrq),
    .listIndex(listIndex)
  );

  // size code, frame index, expected list index (R4)
  localparam int NVEC = 16;
  localparam logic [26:0] VEC [NVEC] = '{
    {3'd0, 14'h3FFF, 10'd1023}, {3'd1, 14'h3FFF, 10'd511},
    {3'd2, 14'h3FFF, 10'd255},  {3'd3, 14'h3FFF, 10'd127},
    {3'd4, 14'h3FFF, 10'd63},   {3'd5, 14'h3FFF, 10'd31},
    {3'd6, 14'h3FFF, 10'd15},   {3'd7, 14'h3FFF, 10'd7},
    {3'd0, 14'h1238, 10'd583},  {3'd1, 14'h1238, 10'd71},
    {3'd2, 14'h1238, 10'd71},   {3'd3, 14'h1238, 10'd71},
    {3'd4, 14'h1238, 10'd7},    {3'd5, 14'h1238, 10'd7},
    {3'd6, 14'h1238, 10'd7},    {3'd7, 14'h1238, 10'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic pulseEvict();
    @(negedge clk); evictDone = 1'b1;
    @(negedge clk); evictDone = 1'b0;
  endtask

  task automatic pulseTick();
    @(negedge clk); thresholdTick = 1'b1;
    @(negedge clk); thresholdTick = 1'b0;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(2'd0, d); check("R1 cmd", d, 0);
    rd(2'd1, d); check("R1 status", d, 0);
    rd(2'd2, d); check("R1 ien", d, 0);
    check("R1 irq", asyncAdvIrq, 0);
    check("R1 busy", ctrlResetBusy, 0);

    // R4 list index table
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, {26'd0, VEC[i][26:24], 3'd0});
      frameIndex = VEC[i][23:10];
      #1;
      check($sformatf("R4 vec %0d", i), listIndex, VEC[i][9:0]);
    end

    // R2 enables, gated by host mode
    wr(2'd0, 32'h6);
    check("R2 async on", asyncSchedOn, 1);
    check("R2 periodic on", periodicSchedOn, 1);
    hostMode = 1'b0; #1;
    check("R2 async gated", asyncSchedOn, 0);
    rd(2'd0, d); check("R2 stored bits", d[2:1], 2'b11);
    hostMode = 1'b1;

    // R3 size code lock
    wr(2'd0, 32'h28);
    rd(2'd0, d); check("R3 size written", d[5:3], 3'd5);
    progListCap = 1'b0;
    wr(2'd0, 32'h18);
    rd(2'd0, d); check("R3 size locked", d[5:3], 3'd5);
    progListCap = 1'b1;

    // R9 device mode doorbell ignored
    hostMode = 1'b0;
    wr(2'd0, 32'h40);
    check("R9 pending", doorbellPending, 0);
    rd(2'd0, d); check("R9 bit6", d[6], 0);
    hostMode = 1'b1;

    // R6 evict without doorbell ignored
    pulseEvict();
    rd(2'd1, d); check("R6 no doorbell", d[0], 0);

    // R5 doorbell set, write 0 keeps it
    wr(2'd0, 32'h40);
    check("R5 pending", doorbellPending, 1);
    wr(2'd0, 32'h00);
    rd(2'd0, d); check("R5 bit6 kept", d[6], 1);

    // R6 handshake timing
    pulseEvict();
    rd(2'd1, d); check("R6 status set", d[0], 1);
    check("R6 doorbell still set", doorbellPending, 1);
    @(negedge clk);
    check("R6 doorbell cleared", doorbellPending, 0);

    // R7 interrupt on threshold (status currently 1, enable 0 so far)
    wr(2'd2, 32'h1);
    repeat (2) @(negedge clk);
    check("R7 no irq before tick", asyncAdvIrq, 0);
    pulseTick();
    check("R7 irq after tick", asyncAdvIrq, 1);
    repeat (3) @(negedge clk);
    check("R7 irq held", asyncAdvIrq, 1);
    wr(2'd1, 32'h1);
    rd(2'd1, d); check("R7 status cleared", d[0], 0);
    check("R7 irq one edge late", asyncAdvIrq, 1);
    @(negedge clk);
    check("R7 irq dropped", asyncAdvIrq, 0);

    // R8 enable off
    wr(2'd2, 32'h0);
    wr(2'd0, 32'h40);
    pulseEvict();
    pulseTick();
    @(negedge clk);
    check("R8 no irq", asyncAdvIrq, 0);
    wr(2'd1, 32'h1);

    // R11 setup: enable, size, doorbell, status, irq
    wr(2'd2, 32'h1);
    wr(2'd0, 32'h6A);
    pulseEvict();
    pulseTick();
    check("R11 irq before reset", asyncAdvIrq, 1);
    wr(2'd0, 32'h6A);

    // R10 reset length; write 0 midway
    wr(2'd0, 32'h05);
    rd(2'd0, d); check("R10 bit0 reads 1", d[0], 1);
    n = 0;
    while (ctrlResetBusy && n < 100) begin
      n++;
      if (n == 4) begin regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'h28; end
      else regWrEn = 1'b0;
      @(negedge clk);
    end
    regWrEn = 1'b0; regWrData = '0;
    check("R10 busy cycles", n, RST_LEN);

    // R11 cleared state
    rd(2'd0, d); check("R11 cmd cleared", d, 0);
    rd(2'd1, d); check("R11 status cleared", d, 0);
    rd(2'd2, d); check("R11 ien kept", d, 1);
    check("R11 irq cleared", asyncAdvIrq, 0);
    check("R11 doorbell cleared", doorbellPending, 0);

    finishRun();
  end

endmodule